// File: doc/BRIEF.md
# Synchronous Exception Entry Unit

This unit handles the entry side of precise synchronous faults such as an illegal-opcode fault or a conditional trap. When the pipeline raises a request, the unit records which kind of fault occurred in a cause word. It saves the address where execution should resume and raises the exception-level status bit. It then sends fetch to the shared exception vector and pulses a flush to the pipeline.

Faults of this kind cannot be masked, so a request takes effect at the first clock edge where it is present. If the faulting instruction sits in the delay slot of a branch, the saved restart address points at that branch, one instruction earlier, and a branch-delay flag in the cause word records the fact. While the exception-level bit is already set, a new fault still updates the code and redirects fetch. It leaves the saved address and the delay flag alone, so the first handler's return point is preserved. A return strobe clears the exception-level bit.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, epc_q, cause_q, vec_pc, exl_q and flush_q are all zero.
- R2: The cycle after a request, cause_q bits 6 down to 2 hold the request's 5-bit code. The illegal-opcode code is 10 and the trap code is 13, and any other value is stored as given. Every cause_q bit other than 6..2 and 31 reads zero.
- R3: A request with exl_q low and in_slot low loads epc_q with fault_pc and clears cause_q bit 31 (branch-delay flag) in the next cycle.
- R4: A request with exl_q low and in_slot high loads epc_q with fault_pc minus 4, wrapping modulo 2^32, and sets cause_q bit 31 in the next cycle.
- R5: A request while exl_q is high leaves epc_q and cause_q bit 31 unchanged. The code field is still updated.
- R6: exl_q is high the cycle after any request. A return strobe with no request clears it the next cycle. A request in the same cycle as a return strobe wins, and exl_q stays high.
- R7: flush_q is high for exactly the cycle after each clock edge at which a request was present, and low otherwise. Back-to-back requests keep it high for one cycle per request.
- R8: The cycle after a request, vec_pc equals 0x80000180 when boot_vec is low and 0xBFC00380 when boot_vec is high (base plus 0x180).
- R9: Without a request, epc_q, cause_q and vec_pc hold their values, whatever fault_pc, in_slot, exc_code, boot_vec and the return strobe do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous fault request, taken at the next edge |
| exc_code | input | 5 | Fault code written into the cause word |
| fault_pc | input | 32 | Address of the faulting instruction |
| in_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| boot_vec | input | 1 | Selects the bootstrap vector base |
| eret | input | 1 | Return strobe, clears the exception level |
| epc_q | output | 32 | Saved restart address |
| cause_q | output | 32 | Cause word: code in bits 6..2, delay flag in bit 31 |
| exl_q | output | 1 | Exception-level status bit |
| vec_pc | output | 32 | Fetch redirect target |
| flush_q | output | 1 | One-cycle pipeline flush per taken request |

## Verification
The case that is hardest to reach is a second fault arriving in a delay slot while the exception level is still set. Here the restart address and delay flag must stay frozen, yet the code and vector must still change. The random stimulus keeps return strobes rare so that the level bit stays set across many requests, and it draws in_slot half the time. Directed sequences add a nested delay-slot fault with a different code, a request coinciding with a return strobe, and a delay-slot fault at address zero that wraps the restart address.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned BD_BIT   = 31;

  localparam logic [CODE_W-1:0] CODE_ILLEGAL = 5'd10;
  localparam logic [CODE_W-1:0] CODE_TRAP    = 5'd13;

  // Resume point: the branch ahead of a delay-slot instruction, else the instruction itself.
  function automatic logic [XLEN-1:0] restart_addr(input logic [XLEN-1:0] pc,
                                                   input logic            slot,
                                                   input logic [XLEN-1:0] step);
    restart_addr = slot ? (pc - step) : pc;
  endfunction

  function automatic logic [XLEN-1:0] vector_addr(input logic            boot,
                                                  input logic [XLEN-1:0] norm_base,
                                                  input logic [XLEN-1:0] boot_base,
                                                  input logic [XLEN-1:0] offset);
    vector_addr = (boot ? boot_base : norm_base) + offset;
  endfunction
endpackage

// File: rtl/exc_status_ctl.sv
module exc_status_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic exc_req,
  input  logic eret,
  output logic exl_q,
  output logic flush_q
);
  logic set_exl;
  logic clr_exl;

  assign set_exl = exc_req;
  assign clr_exl = eret & ~exc_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exl_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= exc_req;
      if (set_exl)      exl_q <= 1'b1;
      else if (clr_exl) exl_q <= 1'b0;
    end
  end

  a_r6_exl_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> exl_q);
  a_r6_exl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !exc_req) |=> !exl_q);
  a_r7_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> flush_q);
  a_r7_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |=> !flush_q);
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic              exl_q,
  input  logic              in_slot,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q,
  output logic              bd_q
);
  logic take_code;
  logic take_bd;

  assign take_code = exc_req;
  assign take_bd   = exc_req & ~exl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      bd_q   <= 1'b0;
    end else begin
      if (take_code) code_q <= code_in;
      if (take_bd)   bd_q   <= in_slot;
    end
  end

  a_r2_code_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> code_q == $past(code_in));
  a_r4_bd_set: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exl_q && in_slot) |=> bd_q);
  a_r3_bd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exl_q && !in_slot) |=> !bd_q);
  a_r5_bd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exl_q) |=> $stable(bd_q));
  a_r9_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |=> $stable(code_q));
endmodule

// File: rtl/exc_epc_capture.sv
module exc_epc_capture
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] INSTR_BYTES = 32'd4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic            exl_q,
  input  logic            in_slot,
  input  logic [XLEN-1:0] fault_pc,
  output logic [XLEN-1:0] epc_q
);
  logic            capture;
  logic [XLEN-1:0] resume_pc;

  assign capture   = exc_req & ~exl_q;
  assign resume_pc = restart_addr(fault_pc, in_slot, INSTR_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n)       epc_q <= '0;
    else if (capture) epc_q <= resume_pc;
  end

  a_r3_epc_own: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exl_q && !in_slot) |=> epc_q == $past(fault_pc));
  a_r4_epc_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exl_q && in_slot) |=> epc_q + INSTR_BYTES == $past(fault_pc));
  a_r5_epc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exl_q) |=> $stable(epc_q));
  a_r9_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |=> $stable(epc_q));
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] NORM_BASE = 32'h8000_0000,
  parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] VEC_OFF   = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic            boot_vec,
  output logic [XLEN-1:0] vec_pc
);
  logic [XLEN-1:0] target;

  assign target = vector_addr(boot_vec, NORM_BASE, BOOT_BASE, VEC_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n)       vec_pc <= '0;
    else if (exc_req) vec_pc <= target;
  end

  a_r8_vec_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && boot_vec) |=> vec_pc - VEC_OFF == BOOT_BASE);
  a_r8_vec_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !boot_vec) |=> vec_pc - VEC_OFF == NORM_BASE);
  a_r9_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |=> $stable(vec_pc));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] NORM_BASE   = 32'h8000_0000,
  parameter logic [XLEN-1:0] BOOT_BASE   = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] VEC_OFF     = 32'h0000_0180,
  parameter logic [XLEN-1:0] INSTR_BYTES = 32'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   fault_pc,
  input  logic              in_slot,
  input  logic              boot_vec,
  input  logic              eret,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   cause_q,
  output logic              exl_q,
  output logic [XLEN-1:0]   vec_pc,
  output logic              flush_q
);
  logic [CODE_W-1:0] code_q;
  logic              bd_q;

  exc_status_ctl u_status (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .eret(eret),
    .exl_q(exl_q), .flush_q(flush_q)
  );

  exc_cause_reg u_cause (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exl_q(exl_q),
    .in_slot(in_slot), .code_in(exc_code), .code_q(code_q), .bd_q(bd_q)
  );

  exc_epc_capture #(.INSTR_BYTES(INSTR_BYTES)) u_epc (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exl_q(exl_q),
    .in_slot(in_slot), .fault_pc(fault_pc), .epc_q(epc_q)
  );

  exc_vector_sel #(.NORM_BASE(NORM_BASE), .BOOT_BASE(BOOT_BASE), .VEC_OFF(VEC_OFF)) u_vec (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .boot_vec(boot_vec), .vec_pc(vec_pc)
  );

  always_comb begin
    cause_q = '0;
    cause_q[CODE_LSB +: CODE_W] = code_q;
    cause_q[BD_BIT] = bd_q;
  end

  a_r2_cause_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & 32'h7FFF_FF83) == 32'h0);
  a_r7_flush_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> exl_q);
endmodule

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] fault_pc = '0;
  logic        in_slot = 1'b0;
  logic        boot_vec = 1'b0;
  logic        eret = 1'b0;
  logic [31:0] epc_q, cause_q, vec_pc;
  logic        exl_q, flush_q;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  // Bench's own view of the architectural state.
  logic [31:0] m_epc = '0;
  logic [4:0]  m_code = '0;
  logic        m_bd = 1'b0;
  logic        m_exl = 1'b0;
  logic [31:0] m_vec = '0;
  logic        m_flush = 1'b0;

  always #5 clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .fault_pc(fault_pc), .in_slot(in_slot), .boot_vec(boot_vec), .eret(eret),
    .epc_q(epc_q), .cause_q(cause_q), .exl_q(exl_q), .vec_pc(vec_pc), .flush_q(flush_q)
  );

  function automatic logic [31:0] want_vec(input logic b);
    return b ? 32'hBFC0_0380 : 32'h8000_0180;
  endfunction

  function automatic logic [31:0] want_epc(input logic [31:0] pc, input logic s);
    logic [31:0] back;
    back = pc + 32'hFFFF_FFFC;
    return s ? back : pc;
  endfunction

  function automatic logic [31:0] want_cause(input logic [4:0] c, input logic b);
    return {b, 24'd0, c, 2'b00};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [4:0] c, input logic [31:0] pc,
                      input logic s, input logic b, input logic e);
    string ereq;
    exc_req = r; exc_code = c; fault_pc = pc; in_slot = s; boot_vec = b; eret = e;
    if (!r)         ereq = "R9";
    else if (m_exl) ereq = "R5";
    else if (s)     ereq = "R4";
    else            ereq = "R3";
    if (r) begin
      m_code = c;
      m_vec  = want_vec(b);
      if (!m_exl) begin
        m_epc = want_epc(pc, s);
        m_bd  = s;
      end
      m_exl = 1'b1;
    end else if (e) begin
      m_exl = 1'b0;
    end
    m_flush = r;
    @(negedge clk);
    chk(ereq, "epc_q", epc_q, m_epc);
    chk(r ? "R2" : "R9", "cause_q", cause_q, want_cause(m_code, m_bd));
    chk("R6", "exl_q", {31'd0, exl_q}, {31'd0, m_exl});
    chk("R7", "flush_q", {31'd0, flush_q}, {31'd0, m_flush});
    chk(r ? "R8" : "R9", "vec_pc", vec_pc, m_vec);
  endtask

  task automatic check_reset_state();
    chk("R1", "epc_q", epc_q, 32'd0);
    chk("R1", "cause_q", cause_q, 32'd0);
    chk("R1", "vec_pc", vec_pc, 32'd0);
    chk("R1", "exl_q", {31'd0, exl_q}, 32'd0);
    chk("R1", "flush_q", {31'd0, flush_q}, 32'd0);
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_unused;
    seed_unused = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check_reset_state();                // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();                // R1 first cycle after release

    // R3: plain illegal-opcode fault, normal vector
    step(1'b1, 5'd10, 32'h0040_1000, 1'b0, 1'b0, 1'b0);
    // R9: idle with noisy inputs
    step(1'b0, 5'd31, 32'hDEAD_BEE0, 1'b1, 1'b1, 1'b0);
    // R5: nested trap in delay slot, boot vector, epc and bd frozen
    step(1'b1, 5'd13, 32'h0040_2004, 1'b1, 1'b1, 1'b0);
    // R6: request and return strobe together, request wins
    step(1'b1, 5'd10, 32'h0040_3000, 1'b1, 1'b0, 1'b1);
    // R6: return strobe alone clears level
    step(1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b1);
    // R4: delay-slot fault at address zero wraps
    step(1'b1, 5'd13, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
    step(1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b1);
    // R7: back-to-back requests keep flush high
    step(1'b1, 5'd13, 32'h0000_1008, 1'b0, 1'b1, 1'b0);
    step(1'b1, 5'd10, 32'h0000_2008, 1'b1, 1'b0, 1'b0);
    step(1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b1);
    // R2: an arbitrary code value is stored as given
    step(1'b1, 5'd7, 32'h0000_3000, 1'b0, 1'b0, 1'b0);
    step(1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic r, s, b, e;
      logic [4:0] c;
      logic [31:0] pc;
      r  = ($urandom % 3) == 0;
      s  = $urandom % 2;
      b  = $urandom % 2;
      e  = ($urandom % 7) == 0;
      c  = ($urandom % 8 == 0) ? 5'($urandom) : (($urandom % 2) ? 5'd13 : 5'd10);
      pc = {$urandom} & 32'hFFFF_FFFC;
      step(r, c, pc, s, b, e);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule